// File: doc/BRIEF.md
# Byte-Wide I/O Unit with Serial Link

This peripheral occupies eight byte addresses in a small processor's I/O space. Two addresses mirror external input pins, two hold output registers that software can read back for read-modify-write, and the other four address a serial link. The serial link uses 8N1 framing at a bit rate fixed when the block is built.

Software queues bytes for sending by writing the data address. The transmitter drains its queue by itself, so software starts nothing. Received bytes land in a circular buffer at a hardware-owned receive index. Software keeps its own read index. A read of the data address returns the buffer slot that the read index selects. When the two indices differ, unread bytes are waiting. Software catches up by copying the receive index into the read index. Reading does not consume anything, and a slow reader loses the oldest bytes to overwrite.

Inside the block, bytes move on valid/ready pairs. The queue accepts a byte only while ready is high, and the bus-facing full flag is the inverse of that ready. The receive buffer never stalls, so the receiver's output carries valid only. The processor bus itself has no back-pressure. Software must test the full flag before it writes.

Top module: `uart_io_unit`

## Requirements
- R1: After reset, both output registers read 0, txd is high, the read index and receive index read 0, and the full flag (address 7, bit 0) reads 0.
- R2: Addresses 0 and 1 return pin_a and pin_b. A write to either address changes nothing: the output registers and the read-back values stay the same.
- R3: A write to address 2 or 3 sets port_c or port_d from the next cycle on. Reading that address returns the stored value.
- R4: A write to address 4 while the queue is not full queues the byte. Without further action, txd then carries a low start bit, the eight data bits LSB first and a high stop bit. Each bit lasts CLK_HZ/BAUD cycles.
- R5: Queued bytes go out back to back, in the order they were written.
- R6: The queue holds DEPTH bytes that wait behind the frame being sent. Address 7 bit 0 reads 1 while the queue is full. A write to address 4 while it is full is dropped.
- R7: Each frame received with a high stop bit is stored at the receive index, and the index then advances by one modulo DEPTH. Address 6 returns that index, zero-extended.
- R8: Address 5 is the read index. A write keeps only the low log2(DEPTH) bits, and a read returns them zero-extended. A read of address 4 returns the receive-buffer slot that the read index selects.
- R9: A frame whose stop bit samples low is discarded. Neither the receive index nor any slot changes.
- R10: When more than DEPTH frames arrive without software reading, the index wraps and the oldest slots are overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| pin_a | input | 8 | Input pins returned at address 0 |
| pin_b | input | 8 | Input pins returned at address 1 |
| port_c | output | 8 | Output register at address 2 |
| port_d | output | 8 | Output register at address 3 |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
Every cycle, the assertions check the following:
- The transmit queue never exceeds its depth.
- A write while full leaves the queue occupancy unchanged.
- Every dequeue drives a start bit next.
- The receive index moves exactly on a stored byte and otherwise holds.
- Register writes land in the output and index registers.

Only the scenarios can show the following:
- The serial bit order, bit timing and the order of queued bytes, which the bench decodes from txd with its own sampler.
- That a bad stop bit discards a frame.
- That the read index selects the right slot after the buffer wraps.

// File: rtl/uio_pkg.sv
package uio_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    REG_PIN_A   = 3'd0,
    REG_PIN_B   = 3'd1,
    REG_OUT_C   = 3'd2,
    REG_OUT_D   = 3'd3,
    REG_DATA    = 3'd4,
    REG_RD_IDX  = 3'd5,
    REG_RX_IDX  = 3'd6,
    REG_TX_FULL = 3'd7
  } reg_addr_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/uio_tx.sv
module uio_tx #(
  parameter int DEPTH = 16,
  parameter int CPB   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [uio_pkg::DW-1:0] in_data,
  output logic                 txd
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(CPB);
  localparam int FW = uio_pkg::DW + 2;

  logic [uio_pkg::DW-1:0] mem [DEPTH];
  logic [IW-1:0] wp, rp;
  logic [IW:0]   cnt;
  logic          busy;
  logic [FW-1:0] frame;
  logic [3:0]    bitn;
  logic [CW-1:0] tick;
  logic          push, pop;

  assign in_ready = (cnt != (IW+1)'(DEPTH));
  assign push     = in_valid && in_ready;
  assign pop      = !busy && (cnt != '0);
  assign txd      = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      frame <= '1;
      bitn  <= '0;
      tick  <= '0;
    end else if (pop) begin
      busy  <= 1'b1;
      frame <= {1'b1, mem[rp], 1'b0};
      bitn  <= '0;
      tick  <= '0;
    end else if (busy) begin
      if (tick == CW'(CPB-1)) begin
        tick  <= '0;
        frame <= {1'b1, frame[FW-1:1]};
        if (bitn == 4'(FW-1)) busy <= 1'b0;
        else                  bitn <= bitn + 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (IW+1)'(DEPTH));
  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !pop) |=> cnt == $past(cnt));
  // R4
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !txd);
endmodule

// File: rtl/uio_rx.sv
module uio_rx #(
  parameter int CPB = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rxd,
  output logic                   out_valid,
  output logic [uio_pkg::DW-1:0] out_data
);
  import uio_pkg::*;
  localparam int CW   = $clog2(CPB);
  localparam int HALF = CPB / 2;

  logic s1, s2;
  rx_state_e st;
  logic [CW-1:0] tick;
  logic [2:0]    bitn;
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      tick      <= '0;
      bitn      <= '0;
      sh        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        RX_IDLE: begin
          tick <= '0;
          if (!s2) st <= RX_START;
        end
        RX_START: begin
          if (tick == CW'(HALF-1)) begin
            tick <= '0;
            bitn <= '0;
            st   <= s2 ? RX_IDLE : RX_BITS;
          end else tick <= tick + 1'b1;
        end
        RX_BITS: begin
          if (tick == CW'(CPB-1)) begin
            tick <= '0;
            sh   <= {s2, sh[DW-1:1]};
            if (bitn == 3'(DW-1)) st <= RX_STOP;
            else                  bitn <= bitn + 1'b1;
          end else tick <= tick + 1'b1;
        end
        RX_STOP: begin
          if (tick == CW'(CPB-1)) begin
            tick <= '0;
            if (s2) begin
              out_valid <= 1'b1;
              out_data  <= sh;
              st        <= RX_IDLE;
            end else begin
              st <= RX_WAIT_HI;
            end
          end else tick <= tick + 1'b1;
        end
        default: begin
          if (s2) st <= RX_IDLE;
        end
      endcase
    end
  end

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: rtl/uio_rx_buf.sv
module uio_rx_buf #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [uio_pkg::DW-1:0]   in_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [uio_pkg::DW-1:0]   rd_data,
  output logic [$clog2(DEPTH)-1:0] rx_idx
);
  localparam int IW = $clog2(DEPTH);

  logic [uio_pkg::DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rx_idx <= '0;
    end else if (in_valid) begin
      mem[rx_idx] <= in_data;
      rx_idx      <= rx_idx + 1'b1;
    end
  end

  assign rd_data = mem[rd_idx];

  // R7
  rx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> rx_idx == IW'($past(rx_idx) + 1'b1));
  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(rx_idx));
endmodule

// File: rtl/uart_io_unit.sv
module uart_io_unit #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int DEPTH  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [7:0] pin_a,
  input  logic [7:0] pin_b,
  output logic [7:0] port_c,
  output logic [7:0] port_d,
  input  logic       rxd,
  output logic       txd
);
  import uio_pkg::*;
  localparam int CPB  = CLK_HZ / BAUD;
  localparam int IW   = $clog2(DEPTH);
  localparam int NOUT = 2;

  logic [DW-1:0] outq [NOUT];
  logic [IW-1:0] rd_idx, rx_idx;
  logic [DW-1:0] buf_q, rx_byte;
  logic          rx_vld, tx_ready, tx_push;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n)                                        outq[g] <= '0;
      else if (wr_en && addr == 3'(int'(REG_OUT_C) + g)) outq[g] <= wr_data;
    end
  end
  assign port_c = outq[0];
  assign port_d = outq[1];

  always_ff @(posedge clk) begin
    if (!rst_n)                           rd_idx <= '0;
    else if (wr_en && addr == REG_RD_IDX) rd_idx <= wr_data[IW-1:0];
  end

  assign tx_push = wr_en && addr == REG_DATA;

  uio_tx #(.DEPTH(DEPTH), .CPB(CPB)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_push), .in_ready(tx_ready),
    .in_data(wr_data), .txd(txd)
  );

  uio_rx #(.CPB(CPB)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .out_valid(rx_vld), .out_data(rx_byte)
  );

  uio_rx_buf #(.DEPTH(DEPTH)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_vld), .in_data(rx_byte),
    .rd_idx(rd_idx), .rd_data(buf_q), .rx_idx(rx_idx)
  );

  always_comb begin
    case (addr)
      REG_PIN_A:  rd_data = pin_a;
      REG_PIN_B:  rd_data = pin_b;
      REG_OUT_C:  rd_data = outq[0];
      REG_OUT_D:  rd_data = outq[1];
      REG_DATA:   rd_data = buf_q;
      REG_RD_IDX: rd_data = DW'(rd_idx);
      REG_RX_IDX: rd_data = DW'(rx_idx);
      default:    rd_data = DW'(!tx_ready);
    endcase
  end

  // R3
  port_c_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_OUT_C) |=> port_c == $past(wr_data));
  // R8
  rd_idx_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_RD_IDX) |=> rd_idx == $past(wr_data[IW-1:0]));
endmodule

// File: tb/tb_uart_io_unit.sv
module tb_uart_io_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CPB = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] addr = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [7:0] pin_a = 0, pin_b = 0;
  logic [7:0] port_c, port_d;
  logic       rxd = 1;
  logic       txd;

  int tests = 0, fails = 0;
  logic [7:0] mon_q [64];
  int mon_n = 0, mon_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_io_unit #(.CLK_HZ(1_600_000), .BAUD(100_000), .DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_a(pin_a), .pin_b(pin_b), .port_c(port_c),
    .port_d(port_d), .rxd(rxd), .txd(txd)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; wr_en = 0;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    @(negedge clk); rxd = 0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = stop;
    repeat (CPB) @(negedge clk);
    rxd = 1;
    repeat (CPB) @(negedge clk);
  endtask

  // serial monitor: independent 8N1 decoder sampling mid-bit
  initial begin
    forever begin
      logic [7:0] b;
      @(negedge txd);
      repeat (CPB/2) @(posedge clk);
      #1;
      for (int i = 0; i < 8; i++) begin
        repeat (CPB) @(posedge clk);
        #1 b[i] = txd;
      end
      repeat (CPB) @(posedge clk);
      #1;
      if (txd !== 1'b1) mon_bad++;
      if (mon_n < 64) mon_q[mon_n] = b;
      mon_n++;
    end
  end

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd2, v); chk("R1 port C reset", v, 8'h00);
    rd(3'd3, v); chk("R1 port D reset", v, 8'h00);
    rd(3'd5, v); chk("R1 read index reset", v, 8'h00);
    rd(3'd6, v); chk("R1 receive index reset", v, 8'h00);
    rd(3'd7, v); chk("R1 full flag reset", v, 8'h00);
    chk("R1 txd idle", {7'b0, txd}, 8'h01);
  endtask

  task automatic t_pins;
    logic [7:0] v;
    pin_a = 8'hA5; pin_b = 8'h3C;
    rd(3'd0, v); chk("R2 pin A read", v, 8'hA5);
    rd(3'd1, v); chk("R2 pin B read", v, 8'h3C);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hEE);
    rd(3'd0, v); chk("R2 pin A after write", v, 8'hA5);
    rd(3'd1, v); chk("R2 pin B after write", v, 8'h3C);
    chk("R2 port C untouched", port_c, 8'h00);
    chk("R2 port D untouched", port_d, 8'h00);
  endtask

  task automatic t_outs;
    logic [7:0] v;
    wr(3'd2, 8'h5A); wr(3'd3, 8'hC3);
    chk("R3 port C pins", port_c, 8'h5A);
    chk("R3 port D pins", port_d, 8'hC3);
    rd(3'd2, v); chk("R3 port C readback", v, 8'h5A);
    rd(3'd3, v); chk("R3 port D readback", v, 8'hC3);
  endtask

  task automatic t_tx_single;
    wr(3'd4, 8'h96);
    repeat (12*CPB) @(negedge clk);
    chk("R4 one frame seen", 8'(mon_n), 8'd1);
    chk("R4 frame data", mon_q[0], 8'h96);
    chk("R4 stop bit high", 8'(mon_bad), 8'd0);
  endtask

  task automatic t_tx_full;
    logic [7:0] v;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      addr = 3'd4; wr_data = 8'(8'h10 + i); wr_en = 1;
    end
    @(negedge clk); wr_en = 0;
    rd(3'd7, v); chk("R6 full flag set", v, 8'h01);
    repeat (19*10*CPB) @(negedge clk);
    chk("R6 eighteenth write dropped", 8'(mon_n), 8'd18);
    for (int i = 0; i < 17; i++)
      chk("R5 order of queued bytes", mon_q[1+i], 8'(8'h10 + i));
    chk("R4 all stop bits high", 8'(mon_bad), 8'd0);
    rd(3'd7, v); chk("R6 full flag clear after drain", v, 8'h00);
  endtask

  task automatic t_rx_basic;
    logic [7:0] v;
    send(8'h3A, 1'b1);
    rd(3'd6, v); chk("R7 index after first byte", v, 8'h01);
    rd(3'd4, v); chk("R8 slot 0 data", v, 8'h3A);
    send(8'hC5, 1'b1);
    rd(3'd6, v); chk("R7 index after second byte", v, 8'h02);
    wr(3'd5, 8'hF1);
    rd(3'd5, v); chk("R8 read index low bits kept", v, 8'h01);
    rd(3'd4, v); chk("R8 slot 1 data", v, 8'hC5);
  endtask

  task automatic t_rx_bad;
    logic [7:0] v;
    send(8'h77, 1'b0);
    rd(3'd6, v); chk("R9 index unchanged on bad stop", v, 8'h02);
    wr(3'd5, 8'h02);
    rd(3'd4, v); chk("R9 slot 2 untouched", v, 8'h00);
    send(8'h81, 1'b1);
    rd(3'd6, v); chk("R9 next good frame stored", v, 8'h03);
    rd(3'd4, v); chk("R9 good frame data", v, 8'h81);
  endtask

  task automatic t_rx_wrap;
    logic [7:0] v;
    for (int i = 0; i < 17; i++) send(8'(8'h40 + i), 1'b1);
    rd(3'd6, v); chk("R10 index wrapped", v, 8'h04);
    wr(3'd5, 8'h03);
    rd(3'd4, v); chk("R10 oldest slot overwritten", v, 8'h50);
    wr(3'd5, 8'h04);
    rd(3'd4, v); chk("R10 next slot kept", v, 8'h41);
    wr(3'd5, 8'h00);
    rd(3'd4, v); chk("R10 slot 0 after wrap", v, 8'h4D);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pins();
    t_outs();
    t_tx_single();
    t_tx_full();
    t_rx_basic();
    t_rx_bad();
    t_rx_wrap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule